// File: doc/BRIEF.md
# Pending Interrupt Priority Resolver

This block chooses the single interrupt source that a handler should service next. It reads a primary status word and two secondary pending words. The primary word carries three kinds of flags. Direct flags name primary-bank sources. Shortcut flags stand in for particular secondary-bank sources. Two summary flags mean "look in secondary bank 1" and "look in secondary bank 2". The resolver applies a fixed order across these groups. It maps a winning shortcut flag back to the real bit number in its own bank. It reports the result as a 7-bit source code made of a 2-bit bank field and a 5-bit bit field.

The answer is rebuilt from the live inputs on every cycle and is never held over. Once a handler clears a source, the next answer moves on to the following source. An optional output register adds one cycle of latency, and the code, valid and error outputs change together. A summary flag that points at an empty secondary word is a malformed input. It is reported on a separate error output instead of as a source.

Top module: `pend_resolver`

## Requirements
- R1: Primary status bits 21 to 31 are ignored. With only those bits set, the outputs are valid=0, err=0 and code=0. Adding them to any other input leaves the outputs unchanged.
- R2: The direct flags are primary bits 0 to 7. If any of them is set, the lowest set one wins with bank 0, and code = bit number.
- R3: The bank 1 shortcut flags are primary bits 10 to 14. Positions 0 to 4 of this field map to bank 1 bits 7, 9, 10, 18 and 19. The lowest set flag wins, and code = 32 + mapped bit.
- R4: The bank 2 shortcut flags are primary bits 15 to 20. Positions 0 to 5 of this field map to bank 2 bits 21, 22, 23, 24, 25 and 30. The lowest set flag wins, and code = 64 + mapped bit.
- R5: Groups are ranked in this order: direct flags, bank 1 shortcuts, bank 2 shortcuts, bank 1 summary (primary bit 8), bank 2 summary (primary bit 9). Only the highest-ranked group that has a flag set decides the output.
- R6: When a summary flag decides, the output is the lowest set bit of that bank's pending word. The code is bank×32 + bit, where bank 1 = 01 and bank 2 = 10 in code bits 6:5.
- R7: When no bit among primary bits 0 to 20 is set, valid=0, err=0 and code=0.
- R8: When a summary flag decides but its bank's pending word is zero, err=1, valid=0 and code=0. Valid and err are never both 1.
- R9: With the output register enabled, the outputs reflect the inputs sampled at the previous rising clock edge. Code, valid and err all update on that same edge.
- R10: While rst_n is low at a clock edge, the registered outputs are cleared to code=0, valid=0 and err=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bank0_stat_i | input | 32 | Primary status word: direct, summary and shortcut flags |
| bank1_pend_i | input | 32 | Secondary bank 1 pending word |
| bank2_pend_i | input | 32 | Secondary bank 2 pending word |
| next_code_o | output | 7 | Chosen source: bank in bits 6:5, bit number in bits 4:0 |
| next_valid_o | output | 1 | A source was chosen |
| next_err_o | output | 1 | A summary flag pointed at an empty pending word |

## Verification
The assertions assume only that the three input words are known, two-valued values at each rising edge. The bench meets this by changing the inputs on falling edges only. Real hardware would set a shortcut flag and also the matching secondary bit. The checks do not rely on that pairing, so the stimulus deliberately breaks it. It pairs shortcut flags with unrelated secondary words and sets summary flags over empty words. It also sweeps every single flag and every pair of flags, plus long pseudo-random mixes.

// File: rtl/rsv_pkg.sv
// Package: shared constants and the shortcut translation for the resolver.
// Assumes the primary word layout: direct, two summaries, then shortcuts.
package rsv_pkg;

    localparam int SC1_N = 5;   // bank 1 shortcut count
    localparam int SC2_N = 6;   // bank 2 shortcut count

    // Map a shortcut field position to its real bit number in its bank.
    function automatic logic [4:0] sc_to_bit(input logic is_b2, input logic [2:0] pos);
        logic [4:0] r;
        r = 5'd0;
        if (!is_b2) begin
            case (pos)
                3'd0: r = 5'd7;
                3'd1: r = 5'd9;
                3'd2: r = 5'd10;
                3'd3: r = 5'd18;
                3'd4: r = 5'd19;
                default: r = 5'd0;
            endcase
        end else begin
            case (pos)
                3'd0: r = 5'd21;
                3'd1: r = 5'd22;
                3'd2: r = 5'd23;
                3'd3: r = 5'd24;
                3'd4: r = 5'd25;
                3'd5: r = 5'd30;
                default: r = 5'd0;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/rsv_first_set.sv
// Lowest-set-bit finder over a W-bit vector.
// Assumes W >= 2; idx is zero when no bit is set.
module rsv_first_set #(
    parameter int W  = 8,
    parameter int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  vec_i,
    output logic          hit_o,
    output logic [IW-1:0] idx_o
);
    // Scan from the top down so that the lowest set bit is written last.
    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                hit_o = 1'b1;
                idx_o = i[IW-1:0];
            end
        end
    end
endmodule

// File: rtl/rsv_shortcut_map.sv
// Finds the lowest set shortcut flag of one bank and translates it to that
// bank's real bit number. Assumes N matches the bank's table length (<= 8).
module rsv_shortcut_map import rsv_pkg::*; #(
    parameter int N     = 5,
    parameter bit BANK2 = 1'b0
) (
    input  logic [N-1:0] field_i,
    output logic         hit_o,
    output logic [4:0]   bit_o
);
    localparam int PW = (N > 1) ? $clog2(N) : 1;

    logic [PW-1:0] pos;

    rsv_first_set #(.W(N), .IW(PW)) u_find (
        .vec_i (field_i),
        .hit_o (hit_o),
        .idx_o (pos)
    );

    // Translate the winning field position through the bank table.
    always_comb bit_o = sc_to_bit(BANK2, 3'(pos));
endmodule

// File: rtl/pend_resolver.sv
// Top: picks the next interrupt source from the primary status word and the
// two secondary pending words. Rank: direct, bank 1 shortcut, bank 2 shortcut,
// bank 1 summary, bank 2 summary. Assumes inputs are synchronous to clk.
module pend_resolver import rsv_pkg::*; #(
    parameter int WORD_W   = 32,
    parameter int DIRECT_N = 8,
    parameter bit OUT_REG  = 1'b1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [WORD_W-1:0]         bank0_stat_i,
    input  logic [WORD_W-1:0]         bank1_pend_i,
    input  logic [WORD_W-1:0]         bank2_pend_i,
    output logic [$clog2(WORD_W)+1:0] next_code_o,
    output logic                      next_valid_o,
    output logic                      next_err_o
);
    localparam int IDX_W    = $clog2(WORD_W);
    localparam int CODE_W   = IDX_W + 2;
    localparam int DIR_IW   = $clog2(DIRECT_N);
    localparam int SUM1_POS = DIRECT_N;
    localparam int SUM2_POS = DIRECT_N + 1;
    localparam int SC1_LO   = DIRECT_N + 2;
    localparam int SC2_LO   = SC1_LO + SC1_N;
    localparam int TOP_POS  = SC2_LO + SC2_N - 1;

    logic              d_hit, s1_hit, s2_hit, p1_hit, p2_hit;
    logic [DIR_IW-1:0] d_idx;
    logic [4:0]        s1_bit, s2_bit;
    logic [IDX_W-1:0]  p1_idx, p2_idx;
    logic              res_valid, res_err;
    logic [1:0]        res_bank;
    logic [IDX_W-1:0]  res_bit;
    logic [CODE_W-1:0] res_code;

    wire unused_high = ^bank0_stat_i[WORD_W-1:TOP_POS+1];

    rsv_first_set #(.W(DIRECT_N), .IW(DIR_IW)) u_direct (
        .vec_i (bank0_stat_i[DIRECT_N-1:0]),
        .hit_o (d_hit),
        .idx_o (d_idx)
    );

    rsv_shortcut_map #(.N(SC1_N), .BANK2(1'b0)) u_sc1 (
        .field_i (bank0_stat_i[SC1_LO+SC1_N-1:SC1_LO]),
        .hit_o   (s1_hit),
        .bit_o   (s1_bit)
    );

    rsv_shortcut_map #(.N(SC2_N), .BANK2(1'b1)) u_sc2 (
        .field_i (bank0_stat_i[SC2_LO+SC2_N-1:SC2_LO]),
        .hit_o   (s2_hit),
        .bit_o   (s2_bit)
    );

    rsv_first_set #(.W(WORD_W), .IW(IDX_W)) u_pend1 (
        .vec_i (bank1_pend_i),
        .hit_o (p1_hit),
        .idx_o (p1_idx)
    );

    rsv_first_set #(.W(WORD_W), .IW(IDX_W)) u_pend2 (
        .vec_i (bank2_pend_i),
        .hit_o (p2_hit),
        .idx_o (p2_idx)
    );

    // Apply the cross-group rank; a summary over an empty word is an error.
    always_comb begin
        res_valid = 1'b0;
        res_err   = 1'b0;
        res_bank  = 2'd0;
        res_bit   = '0;
        if (d_hit) begin
            res_valid = 1'b1;
            res_bank  = 2'd0;
            res_bit   = IDX_W'(d_idx);
        end else if (s1_hit) begin
            res_valid = 1'b1;
            res_bank  = 2'd1;
            res_bit   = IDX_W'(s1_bit);
        end else if (s2_hit) begin
            res_valid = 1'b1;
            res_bank  = 2'd2;
            res_bit   = IDX_W'(s2_bit);
        end else if (bank0_stat_i[SUM1_POS]) begin
            res_valid = p1_hit;
            res_err   = !p1_hit;
            res_bank  = 2'd1;
            res_bit   = p1_idx;
        end else if (bank0_stat_i[SUM2_POS]) begin
            res_valid = p2_hit;
            res_err   = !p2_hit;
            res_bank  = 2'd2;
            res_bit   = p2_idx;
        end
    end

    // Force the code to zero whenever no source is chosen.
    always_comb res_code = res_valid ? {res_bank, res_bit} : '0;

    generate
        if (OUT_REG) begin : g_reg
            logic chk_live;

            // Register the result; code, valid and error move together.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    next_code_o  <= '0;
                    next_valid_o <= 1'b0;
                    next_err_o   <= 1'b0;
                end else begin
                    next_code_o  <= res_code;
                    next_valid_o <= res_valid;
                    next_err_o   <= res_err;
                end
            end

            // Marks cycles whose previous edge was already out of reset.
            always_ff @(posedge clk) begin
                if (!rst_n) chk_live <= 1'b0;
                else        chk_live <= 1'b1;
            end

            assert_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
                chk_live |-> (next_valid_o == $past(res_valid)) &&
                             (next_err_o == $past(res_err)) &&
                             (next_code_o == $past(res_code)));
        end else begin : g_comb
            // Pass the result straight through.
            always_comb begin
                next_code_o  = res_code;
                next_valid_o = res_valid;
                next_err_o   = res_err;
            end
        end
    endgenerate

    assert_never_both_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(next_valid_o && next_err_o));

    assert_idle_code_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !next_valid_o |-> (next_code_o == '0));

    assert_high_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bank0_stat_i[TOP_POS:0] == '0) |-> (!res_valid && !res_err));

    assert_direct_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|bank0_stat_i[DIRECT_N-1:0]) |->
            (res_valid && res_bank == 2'd0 && bank0_stat_i[res_bit]));

    assert_summary_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !d_hit && !s1_hit && !s2_hit && res_bank == 2'd1) |->
            bank1_pend_i[res_bit]);

    assert_empty_summary_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bank0_stat_i[SUM1_POS] && !d_hit && !s1_hit && !s2_hit &&
         bank1_pend_i == '0) |-> res_err);
endmodule

// File: tb/sim_pend_resolver.sv
module sim_pend_resolver;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] s0 = '0, p1 = '0, p2 = '0;
    logic [6:0]  code;
    logic        valid, err;
    int          n_vec = 0;
    int          n_bad = 0;
    bit          reported = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    pend_resolver u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .bank0_stat_i (s0),
        .bank1_pend_i (p1),
        .bank2_pend_i (p2),
        .next_code_o  (code),
        .next_valid_o (valid),
        .next_err_o   (err)
    );

    function automatic logic [4:0] tb_sc1(input int p);
        case (p) 0: return 5'd7; 1: return 5'd9; 2: return 5'd10;
                 3: return 5'd18; default: return 5'd19; endcase
    endfunction

    function automatic logic [4:0] tb_sc2(input int p);
        case (p) 0: return 5'd21; 1: return 5'd22; 2: return 5'd23;
                 3: return 5'd24; 4: return 5'd25; default: return 5'd30; endcase
    endfunction

    function automatic int lowest(input logic [31:0] w);
        for (int i = 0; i < 32; i++) if (w[i]) return i;
        return -1;
    endfunction

    // Expected {err, valid, code} from the requirements.
    function automatic logic [8:0] model(input logic [31:0] s, a, b);
        int k;
        k = lowest({24'd0, s[7:0]});
        if (k >= 0) return {2'b01, 2'd0, 5'(k)};
        k = lowest({27'd0, s[14:10]});
        if (k >= 0) return {2'b01, 2'd1, tb_sc1(k)};
        k = lowest({26'd0, s[20:15]});
        if (k >= 0) return {2'b01, 2'd2, tb_sc2(k)};
        if (s[8]) begin
            k = lowest(a);
            if (k < 0) return {2'b10, 7'd0};
            return {2'b01, 2'd1, 5'(k)};
        end
        if (s[9]) begin
            k = lowest(b);
            if (k < 0) return {2'b10, 7'd0};
            return {2'b01, 2'd2, 5'(k)};
        end
        return 9'd0;
    endfunction

    task automatic check(input string tag, input logic [8:0] got, input logic [8:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s s0=%h p1=%h p2=%h actual err/valid/code=%b/%b/%0d expected=%b/%b/%0d",
                     tag, s0, p1, p2, got[8], got[7], got[6:0], exp[8], exp[7], exp[6:0]);
        end
    endtask

    // Drive at a falling edge, let one rising edge register it, sample next falling edge.
    task automatic apply(input logic [31:0] s, a, b, input string tag);
        s0 = s; p1 = a; p2 = b;
        @(posedge clk);
        @(negedge clk);
        check(tag, {err, valid, code}, model(s, a, b));
    endtask

    task automatic summary();
        if (!reported) begin
            reported = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog R9 actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] seed;
        seed = 32'h1234_5678;
        // R10: reset clears outputs even with busy inputs.
        s0 = 32'h0000_00FF; p1 = '1; p2 = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10", {err, valid, code}, 9'd0);
        rst_n = 1'b1;
        s0 = '0; p1 = '0; p2 = '0;
        @(posedge clk);
        @(negedge clk);
        check("R7", {err, valid, code}, 9'd0);

        // Every single primary bit, with non-empty secondary words.
        for (int b = 0; b < 32; b++) begin
            if (b < 8)        apply(32'(1) << b, 32'h0008_0400, 32'h4000_0000, "R2");
            else if (b < 10)  apply(32'(1) << b, 32'h0008_0400, 32'h4000_0000, "R6");
            else if (b < 15)  apply(32'(1) << b, 32'h0000_0001, 32'h0000_0001, "R3");
            else if (b < 21)  apply(32'(1) << b, 32'h0000_0001, 32'h0000_0001, "R4");
            else              apply(32'(1) << b, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R1");
        end
        // R1: high bits added to each considered bit change nothing.
        for (int b = 0; b < 21; b++)
            apply((32'(1) << b) | 32'hFFE0_0000, 32'h0000_0100, 32'h0000_0200, "R1");
        apply(32'hFFE0_0000, 32'h0, 32'h0, "R1");

        // R5: every pair of considered bits.
        for (int a = 0; a < 21; a++)
            for (int b = 0; b < 21; b++)
                apply((32'(1) << a) | (32'(1) << b), 32'h0010_0000, 32'h8000_0000, "R5");

        // R6: summaries select the lowest pending bit of their bank.
        for (int k = 0; k < 32; k++) begin
            apply(32'h0000_0100, 32'hFFFF_FFFF << k, 32'h0000_0001, "R6");
            apply(32'h0000_0200, 32'h0000_0001, 32'(1) << k, "R6");
            apply(32'h0000_0300, 32'h0, 32'(1) << k, "R8");
        end
        // R8: summary over an empty word.
        apply(32'h0000_0100, 32'h0, 32'hFFFF_FFFF, "R8");
        apply(32'h0000_0200, 32'hFFFF_FFFF, 32'h0, "R8");
        apply(32'h0000_0000, 32'h0, 32'h0, "R7");

        // R9: outputs hold until the next rising edge, then all update together.
        apply(32'h0000_0004, 32'h0, 32'h0, "R9");
        s0 = 32'h0000_4000;
        #1;
        check("R9", {err, valid, code}, model(32'h0000_0004, 32'h0, 32'h0));
        @(posedge clk);
        @(negedge clk);
        check("R9", {err, valid, code}, model(32'h0000_4000, 32'h0, 32'h0));

        // R5: pseudo-random mixes, sparse primary words, sometimes empty banks.
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r1, r2, r3, r4;
            seed = seed * 32'd1664525 + 32'd1013904223; r1 = seed;
            seed = seed * 32'd1664525 + 32'd1013904223; r2 = seed;
            seed = seed * 32'd1664525 + 32'd1013904223; r3 = seed;
            seed = seed * 32'd1664525 + 32'd1013904223; r4 = seed;
            apply(r1 & r2 & (i[0] ? 32'hFFFF_FF00 : 32'hFFFF_FFFF),
                  (i % 5 == 0) ? 32'h0 : (r3 & r4),
                  (i % 7 == 0) ? 32'h0 : (r3 ^ r4), "R5");
        end

        summary();
        $finish;
    end
endmodule